// File: doc/BRIEF.md
# Limb Funnel Shifter with Carry Merge

This unit performs one step of a shift across an arbitrary-precision integer made of 64-bit limbs. Each call takes one source limb, a 64-bit carry-in word, a 64-bit amount word and a direction select. It returns the shifted limb and a full-width carry-out word that holds the bits pushed off the edge of the limb.

In right mode, the bits that leave the bottom of the limb reappear at the top of the carry-out. The vacated top positions of the result are filled from the carry-in. In left mode, the bits that leave the top reappear at the bottom of the carry-out, and the vacated low positions are filled from the carry-in.

A wide right shift walks the limbs from most to least significant. A wide left shift walks them from least to most significant. In both cases each limb's carry-out is fed back in as the next limb's carry-in. Internally the unit forms a 128-bit double word and rotates it. The half that holds the moved limb is merged with the carry-in under a fill mask.

The outputs are combinational by default. A parameter adds one register stage with an asynchronous active-low clear.

Top module: `fshift_limb`

## Requirements
- R1: The shift count n is taken from bits [5:0] of `amt_word` only, giving 0 to 63. Bits [63:6] have no effect on either output.
- R2: With `dir_left`=0 (right), `res_limb` equals `src_limb` shifted right logically by n, ORed with the n most significant bits of `carry_in`. The other bits of `carry_in` are dropped.
- R3: With `dir_left`=0, `carry_out` holds bits [n-1:0] of `src_limb` in positions [63:64-n]. All other positions are zero.
- R4: With `dir_left`=1 (left), `res_limb` equals `src_limb` shifted left by n, ORed with the n least significant bits of `carry_in`.
- R5: With `dir_left`=1, `carry_out` holds bits [63:64-n] of `src_limb` in positions [n-1:0]. All other positions are zero.
- R6: When n=0, `res_limb` equals `src_limb` in either direction, `carry_in` has no effect, and `carry_out` is zero.
- R7: Every set bit of `src_limb` appears exactly once: either in a non-filled position of `res_limb` or in `carry_out`.
- R8: The direction select is a single bit: 0 selects right and 1 selects left.
- R9: With `OUT_REG`=1, both outputs appear one clock after their inputs, and both are zero while `rst_n` is low. With `OUT_REG`=0, both outputs follow the inputs with no clock.
- R10: Chaining limbs through carry-out to carry-in yields the correct multi-limb shift, including the incoming word at the far end and the spill word leaving the near end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Asynchronous active-low clear of the output stage |
| src_limb | input | 64 | Limb to be shifted |
| carry_in | input | 64 | Word merged into the vacated positions |
| amt_word | input | 64 | Amount word; only bits [5:0] are used |
| dir_left | input | 1 | 0 = shift right, 1 = shift left |
| res_limb | output | 64 | Shifted limb with carry-in merged |
| carry_out | output | 64 | Bits shifted out of the limb |

## Verification
The properties assume that the inputs are stable at each rising clock edge. In registered mode, they also assume that the sampled values are the ones the output stage captured. The bench meets this by changing inputs only on falling edges and holding them for a full cycle.

The conservation and fill-placement properties need no input constraint, because every 64-bit combination of limb, carry word and count is legal. The stimulus still deliberately includes all-ones and all-zero carry words and counts of 0, 32 and 63. It also includes amount words with junk in their upper bits, so the masking boundaries are actually exercised.

// File: rtl/fshift_pkg.sv
`timescale 1ns/1ps
package fshift_pkg;

  typedef enum logic {
    SHDIR_RIGHT = 1'b0,
    SHDIR_LEFT  = 1'b1
  } shdir_e;

endpackage

// File: rtl/fshift_amt_dec.sv
`timescale 1ns/1ps
// Extracts the shift count and builds the two candidate fill masks.
module fshift_amt_dec #(
  parameter int DATA_W = 64,
  parameter int AMT_W  = 64,
  localparam int SHW   = $clog2(DATA_W)
) (
  input  logic [AMT_W-1:0]  amt_word,
  output logic [SHW-1:0]    n_sh,
  output logic [DATA_W-1:0] hi_mask,
  output logic [DATA_W-1:0] lo_mask
);

  logic unused_amt_hi;
  assign unused_amt_hi = ^amt_word[AMT_W-1:SHW];

  assign n_sh = amt_word[SHW-1:0];

  // Bit i is a low fill position when i < n; it is a high fill position
  // when its distance from the top is below n.
  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign lo_mask[i] = (n_sh > SHW'(i));
    assign hi_mask[i] = (n_sh > SHW'(DATA_W - 1 - i));
  end

endmodule

// File: rtl/fshift_funnel.sv
`timescale 1ns/1ps
// Double-width rotate: yields the moved limb and the spill word.
module fshift_funnel #(
  parameter int DATA_W = 64,
  localparam int SHW   = $clog2(DATA_W),
  localparam int DW    = 2 * DATA_W,
  localparam int RW    = $clog2(DW) + 1
) (
  input  logic [DATA_W-1:0] src_limb,
  input  logic [SHW-1:0]    n_sh,
  input  fshift_pkg::shdir_e mode,
  output logic [DATA_W-1:0] moved,
  output logic [DATA_W-1:0] spill
);

  localparam logic [RW-1:0] DW_AMT = RW'(DW);

  function automatic logic [DW-1:0] rotl_dw(input logic [DW-1:0] v,
                                            input logic [RW-1:0] k);
    logic [RW-1:0] back;
    back = DW_AMT - k;
    return (v << k) | (v >> back);
  endfunction

  logic [DW-1:0] dw_in;
  logic [DW-1:0] dw_rot;
  logic [RW-1:0] rot_amt;

  always_comb begin
    if (mode == fshift_pkg::SHDIR_RIGHT) begin
      // Rotating left by (2W - n) equals a right rotate by n.
      dw_in   = {src_limb, {DATA_W{1'b0}}};
      rot_amt = DW_AMT - RW'(n_sh);
    end else begin
      dw_in   = {{DATA_W{1'b0}}, src_limb};
      rot_amt = RW'(n_sh);
    end
    dw_rot = rotl_dw(dw_in, rot_amt);
    if (mode == fshift_pkg::SHDIR_RIGHT) begin
      moved = dw_rot[DW-1:DATA_W];
      spill = dw_rot[DATA_W-1:0];
    end else begin
      moved = dw_rot[DATA_W-1:0];
      spill = dw_rot[DW-1:DATA_W];
    end
  end

endmodule

// File: rtl/fshift_merge.sv
`timescale 1ns/1ps
// Picks the fill mask for the direction and ORs the carry word into it.
module fshift_merge #(
  parameter int DATA_W = 64
) (
  input  fshift_pkg::shdir_e mode,
  input  logic [DATA_W-1:0] moved,
  input  logic [DATA_W-1:0] spill,
  input  logic [DATA_W-1:0] carry_in,
  input  logic [DATA_W-1:0] hi_mask,
  input  logic [DATA_W-1:0] lo_mask,
  output logic [DATA_W-1:0] fill_mask,
  output logic [DATA_W-1:0] merged,
  output logic [DATA_W-1:0] spill_out
);

  function automatic logic [DATA_W-1:0] masked_or(input logic [DATA_W-1:0] base,
                                                   input logic [DATA_W-1:0] extra,
                                                   input logic [DATA_W-1:0] msk);
    return base | (extra & msk);
  endfunction

  assign fill_mask = (mode == fshift_pkg::SHDIR_LEFT) ? lo_mask : hi_mask;
  assign merged    = masked_or(moved, carry_in, fill_mask);
  assign spill_out = spill;

endmodule

// File: rtl/fshift_outstage.sv
`timescale 1ns/1ps
// Optional output register, chosen by OUT_REG.
module fshift_outstage #(
  parameter int DATA_W  = 64,
  parameter bit OUT_REG = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] res_d,
  input  logic [DATA_W-1:0] cout_d,
  output logic [DATA_W-1:0] res_q,
  output logic [DATA_W-1:0] cout_q
);

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        res_q  <= '0;
        cout_q <= '0;
      end else begin
        res_q  <= res_d;
        cout_q <= cout_d;
      end
    end
  end else begin : g_pass
    logic unused_clkrst;
    assign unused_clkrst = clk ^ rst_n;
    assign res_q  = res_d;
    assign cout_q = cout_d;
  end

endmodule

// File: rtl/fshift_limb.sv
`timescale 1ns/1ps
module fshift_limb #(
  parameter int DATA_W  = 64,
  parameter int AMT_W   = 64,
  parameter bit OUT_REG = 1'b0,
  localparam int SHW    = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] src_limb,
  input  logic [DATA_W-1:0] carry_in,
  input  logic [AMT_W-1:0]  amt_word,
  input  logic              dir_left,
  output logic [DATA_W-1:0] res_limb,
  output logic [DATA_W-1:0] carry_out
);

  fshift_pkg::shdir_e mode;
  assign mode = fshift_pkg::shdir_e'(dir_left);

  // Named internal events, observed by the bound checker.
  logic [SHW-1:0]    n_sh;
  logic [DATA_W-1:0] hi_mask;
  logic [DATA_W-1:0] lo_mask;
  logic [DATA_W-1:0] moved;
  logic [DATA_W-1:0] spill;
  logic [DATA_W-1:0] fill_mask;
  logic [DATA_W-1:0] comb_res;
  logic [DATA_W-1:0] comb_cout;

  fshift_amt_dec #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_dec (
    .amt_word (amt_word),
    .n_sh     (n_sh),
    .hi_mask  (hi_mask),
    .lo_mask  (lo_mask)
  );

  fshift_funnel #(.DATA_W(DATA_W)) u_fun (
    .src_limb (src_limb),
    .n_sh     (n_sh),
    .mode     (mode),
    .moved    (moved),
    .spill    (spill)
  );

  fshift_merge #(.DATA_W(DATA_W)) u_mrg (
    .mode      (mode),
    .moved     (moved),
    .spill     (spill),
    .carry_in  (carry_in),
    .hi_mask   (hi_mask),
    .lo_mask   (lo_mask),
    .fill_mask (fill_mask),
    .merged    (comb_res),
    .spill_out (comb_cout)
  );

  fshift_outstage #(.DATA_W(DATA_W), .OUT_REG(OUT_REG)) u_out (
    .clk    (clk),
    .rst_n  (rst_n),
    .res_d  (comb_res),
    .cout_d (comb_cout),
    .res_q  (res_limb),
    .cout_q (carry_out)
  );

endmodule

// File: rtl/fshift_limb_chk.sv
`timescale 1ns/1ps
module fshift_limb_chk #(
  parameter int DATA_W  = 64,
  parameter bit OUT_REG = 1'b0,
  localparam int SHW    = $clog2(DATA_W)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] src_limb,
  input logic [DATA_W-1:0] carry_in,
  input logic              dir_left,
  input logic [SHW-1:0]    n_sh,
  input logic [DATA_W-1:0] fill_mask,
  input logic [DATA_W-1:0] comb_res,
  input logic [DATA_W-1:0] comb_cout,
  input logic [DATA_W-1:0] res_limb,
  input logic [DATA_W-1:0] carry_out
);

  AST_ZERO_SHIFT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (n_sh == '0) |-> (comb_res == src_limb && comb_cout == '0)); // R6

  AST_FILL_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(fill_mask) == int'(n_sh)); // R1

  AST_RIGHT_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_left |-> ((comb_res & fill_mask) == (carry_in & fill_mask))); // R2

  AST_LEFT_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    dir_left |-> ((comb_res & fill_mask) == (carry_in & fill_mask))); // R4

  AST_SPILL_IN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (comb_cout & ~fill_mask) == '0); // R3 R5

  AST_BIT_CONSERVE: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(comb_res & ~fill_mask) + $countones(comb_cout))
      == $countones(src_limb)); // R7

  if (OUT_REG) begin : g_lat
    logic past_ok;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
    end
    AST_REG_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> (res_limb == $past(comb_res) && carry_out == $past(comb_cout))); // R9
  end else begin : g_nolat
    AST_COMB_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (res_limb == comb_res) && (carry_out == comb_cout)); // R9
  end

endmodule

bind fshift_limb fshift_limb_chk #(.DATA_W(DATA_W), .OUT_REG(OUT_REG)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .src_limb  (src_limb),
  .carry_in  (carry_in),
  .dir_left  (dir_left),
  .n_sh      (n_sh),
  .fill_mask (fill_mask),
  .comb_res  (comb_res),
  .comb_cout (comb_cout),
  .res_limb  (res_limb),
  .carry_out (carry_out)
);

// File: tb/tb_fshift_limb.sv
`timescale 1ns/1ps
module tb_fshift_limb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src_limb = '0;
  logic [63:0] carry_in = '0;
  logic [63:0] amt_word = '0;
  logic        dir_left = 1'b0;
  logic [63:0] res_limb;
  logic [63:0] carry_out;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  fshift_limb #(.DATA_W(64), .AMT_W(64), .OUT_REG(1'b1)) dut (
    .clk (clk), .rst_n (rst_n), .src_limb (src_limb), .carry_in (carry_in),
    .amt_word (amt_word), .dir_left (dir_left),
    .res_limb (res_limb), .carry_out (carry_out)
  );

  localparam int NV = 9;
  localparam logic [63:0] T_SRC [NV] = '{
    64'hFFFF_FFFF_FFFF_FFFF, 64'h4000_0000_0000_0001, 64'h0123_4567_89AB_CDEF,
    64'h0123_4567_89AB_CDEF, 64'h8000_8000_8000_8001, 64'h8000_0000_0000_0003,
    64'h8000_0000_0000_0003, 64'hDEAD_BEEF_0000_1111, 64'h1234_5678_9ABC_DEF0};
  localparam logic [63:0] T_CIN [NV] = '{
    64'h1000_0000_0000_0000, 64'h0000_0000_0000_000A, 64'hFFFF_FFFF_FFFF_FFFF,
    64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF,
    64'h0000_0000_0000_0000, 64'h0000_0000_0000_5555, 64'hFFFF_FFFF_FFFF_FFFF};
  localparam logic [63:0] T_AMT [NV] = '{
    64'd4, 64'd4, 64'd0, 64'd0, 64'hFFFF_FFFF_FFFF_FFC4, 64'd63, 64'd63,
    64'h0000_0000_0000_0040, 64'd32};
  localparam logic T_LEFT [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1};
  localparam logic [63:0] T_RES [NV] = '{
    64'h1FFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_001A, 64'h0123_4567_89AB_CDEF,
    64'h0123_4567_89AB_CDEF, 64'h0800_0800_0800_0800, 64'hFFFF_FFFF_FFFF_FFFF,
    64'h8000_0000_0000_0000, 64'hDEAD_BEEF_0000_1111, 64'h9ABC_DEF0_FFFF_FFFF};
  localparam logic [63:0] T_COUT [NV] = '{
    64'hF000_0000_0000_0000, 64'h0000_0000_0000_0004, 64'h0000_0000_0000_0000,
    64'h0000_0000_0000_0000, 64'h1000_0000_0000_0000, 64'h0000_0000_0000_0006,
    64'h4000_0000_0000_0001, 64'h0000_0000_0000_0000, 64'h0000_0000_1234_5678};
  localparam string T_TAG [NV] = '{
    "R2 R3", "R4 R5", "R6 R8", "R6 R8", "R1", "R2 R3", "R4 R5", "R1 R6", "R4 R5"};

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Bit-by-bit restatement of the requirements.
  task automatic bit_model(input logic [63:0] s, input logic [63:0] c, input int n,
                           input logic lft, output logic [63:0] r, output logic [63:0] o);
    for (int i = 0; i < 64; i++) begin
      if (!lft) begin
        r[i] = (i + n < 64) ? s[i+n] : c[i];
        o[i] = (i >= 64 - n) ? s[i-(64-n)] : 1'b0;
      end else begin
        r[i] = (i >= n) ? s[i-n] : c[i];
        o[i] = (i < n) ? s[64-n+i] : 1'b0;
      end
    end
  endtask

  task automatic apply(input logic [63:0] s, input logic [63:0] c,
                       input logic [63:0] a, input logic lft);
    @(negedge clk);
    src_limb = s; carry_in = c; amt_word = a; dir_left = lft;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [63:0] mr, mo, spill;
    // R9: cleared while reset is held even with live inputs
    src_limb = 64'hFFFF_FFFF_FFFF_FFFF; carry_in = 64'hFFFF_FFFF_FFFF_FFFF;
    amt_word = 64'd7; dir_left = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 reset res", res_limb, 64'h0);
    check("R9 reset cout", carry_out, 64'h0);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      apply(T_SRC[v], T_CIN[v], T_AMT[v], T_LEFT[v]);
      check({T_TAG[v], " res"}, res_limb, T_RES[v]);
      check({T_TAG[v], " cout"}, carry_out, T_COUT[v]);
      bit_model(T_SRC[v], T_CIN[v], int'(T_AMT[v][5:0]), T_LEFT[v], mr, mo);
      check({T_TAG[v], " R8 model res"}, res_limb, mr);
      check({T_TAG[v], " R8 model cout"}, carry_out, mo);
    end

    // R1: junk in the upper amount bits changes nothing
    for (int k = 0; k < 4; k++) begin
      apply(64'hA5A5_5A5A_0F0F_F0F0, 64'h1357_9BDF_2468_ACE0,
            {58'h2AA_AAAA_AAAA_AAAA ^ 58'(k * 58'h13579), 6'd13}, k[0]);
      bit_model(64'hA5A5_5A5A_0F0F_F0F0, 64'h1357_9BDF_2468_ACE0, 13, k[0], mr, mo);
      check("R1 junk amount res", res_limb, mr);
      check("R1 junk amount cout", carry_out, mo);
    end

    // R9: one-cycle latency - new inputs not visible before the edge
    @(negedge clk);
    src_limb = 64'h1; carry_in = '0; amt_word = 64'd1; dir_left = 1'b1;
    #1;
    check("R9 latency hold", res_limb, mr);
    @(negedge clk);
    check("R9 latency update", res_limb, 64'h2);

    // R10: three-limb right shift by 4, top limb first
    spill = 64'h9000_0000_0000_0000;
    apply(64'h0000_0000_5000_0002, spill, 64'd4, 1'b0);
    check("R10 right limb2", res_limb, 64'h9000_0000_0500_0000);
    spill = carry_out;
    apply(64'h8000_8000_8000_8001, spill, 64'd4, 1'b0);
    check("R10 right limb1", res_limb, 64'h2800_0800_0800_0800);
    spill = carry_out;
    apply(64'hFFFF_FFFF_FFFF_FFFF, spill, 64'd4, 1'b0);
    check("R10 right limb0", res_limb, 64'h1FFF_FFFF_FFFF_FFFF);
    check("R10 right spill", carry_out, 64'hF000_0000_0000_0000);

    // R10: three-limb left shift by 4, bottom limb first
    spill = 64'hA;
    apply(64'h4000_0000_0000_0001, spill, 64'd4, 1'b1);
    check("R10 left limb0", res_limb, 64'h0000_0000_0000_001A);
    spill = carry_out;
    apply(64'h3FFF_FFFF_FFFF_FFFF, spill, 64'd4, 1'b1);
    check("R10 left limb1", res_limb, 64'hFFFF_FFFF_FFFF_FFF4);
    spill = carry_out;
    apply(64'h9000_0000_0001_0002, spill, 64'd4, 1'b1);
    check("R10 left limb2", res_limb, 64'h0000_0000_0010_0023);
    check("R10 left spill", carry_out, 64'h9);

    // R7: conservation over a sweep of counts in both directions
    for (int n = 0; n < 64; n += 9) begin
      apply(64'hC3A5_0FF0_1234_8001, 64'h0, 64'(n), n[0]);
      check("R7 popcount", 64'($countones(res_limb) + $countones(carry_out)),
            64'($countones(64'hC3A5_0FF0_1234_8001)));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule